// File: doc/BRIEF.md
# Folded SHA-256 Compression Engine

This block runs the 64 rounds of the SHA-256 compression function on eight 32-bit working words. Between register stages it evaluates a group of rounds as one combinational chain. A parameter sets the group size, so each clock advances the state by 1, 2, 4 or 8 rounds. After the last group it adds the starting chaining value back into the result, word by word, and presents the 256-bit digest with a one-cycle completion pulse.

The block does not hold the round constants and does not schedule the message. A neighbouring expander supplies one pre-added W+K word per round. During each running cycle the block reports which group of rounds it is consuming, and the expander places the words for that group on the `wk_in` bus. A host pulses `start` with the initial eight-word state on `init_state`. The block latches that state and returns to idle when the digest is ready.

The controller is a four-state machine. `ST_IDLE` waits for a start. The transition *launch* (start seen in idle) loads the working and chaining registers and enters `ST_ROUNDS`. `ST_ROUNDS` applies one group per clock. The transition *last group* (the final group index) moves to `ST_FEED`. `ST_FEED` adds the chaining words in and registers the digest. The transition *commit* always leads to `ST_DONE`, which raises `done` for one cycle. The transition *retire* always returns the machine to `ST_IDLE`.

Top module: `sha_fold_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`, `done`, `grp_idx` and `digest` are all zero. This holds even when reset arrives in the middle of a run.
- R2: `start` is accepted only while `busy` is low. After an accepted start, `busy` is high on the next cycle and `grp_idx` is 0. A `start` raised while `busy` is high changes neither the timing nor the result of the run in progress.
- R3: In running cycle n (n from 0 to 64/RPC-1), `grp_idx` equals n. Bits [32j+31:32j] of `wk_in` carry the W+K word for round n*RPC+j.
- R4: Each round uses Ch(x,y,z)=z^(x&(y^z)), Maj(x,y,z)=(x&(y|z))|(y&z), S0=rotr2^rotr13^rotr22 and S1=rotr6^rotr11^rotr25. With T1=h+S1(e)+Ch(e,f,g)+WK, the new a is T1+S0(a)+Maj(a,b,c) and the new e is d+T1. The other words shift: b←a, c←b, d←c, f←e, g←f, h←g.
- R5: The digest is the final working state plus the latched initial state, added per word modulo 2^32. Word a sits in bits [255:224] and word h sits in bits [31:0]. The same layout applies to `init_state`.
- R6: `done` is high for exactly one cycle, in the cycle that follows 64/RPC+2 clock edges after the start edge. `busy` is high from the cycle after the start edge through the `done` cycle.
- R7: `digest` changes only at the end of `ST_FEED`. It holds its value while idle and while the next run is in progress.
- R8: RPC may be 1, 2, 4 or 8, and every setting gives the same digest. With the standard initial vector and the padded one-block message "abc", the digest is ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R9: Changes on `init_state` after the start edge have no effect on the digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled in idle |
| init_state | input | 256 | Initial working and chaining state, word a in the top bits |
| wk_in | input | 32*RPC | W+K words for the group named by `grp_idx` |
| busy | output | 1 | High from launch through completion |
| done | output | 1 | One-cycle completion pulse |
| grp_idx | output | log2(64/RPC) | Index of the round group being consumed |
| digest | output | 256 | Feed-forward result of the last completed run |

## Verification
The rounds mix every bit into every other within a few steps. A wrong round function, a swapped word, a misplaced W+K lane or a missed feed-forward word therefore corrupts nearly all 256 digest bits, and this shows up in the first `done` cycle of that run. A wrong state or group counter shows up sooner. `busy`, `done` or `grp_idx` departs from a cycle count kept in the bench within one clock of the fault. A group index that is off by one also feeds the wrong words and spoils the digest. Four instances with different folding factors share one stimulus, so an error that only appears at a given chain depth is caught against the same expected digest.

// File: rtl/sha_fold_pkg.sv
package sha_fold_pkg;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] d;
        logic [31:0] e;
        logic [31:0] f;
        logic [31:0] g;
        logic [31:0] h;
    } sha_work_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROUNDS,
        ST_FEED,
        ST_DONE
    } fold_state_e;

    function automatic logic [31:0] rotr(input logic [31:0] x, input int unsigned n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [31:0] big_s0(input logic [31:0] x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic logic [31:0] big_s1(input logic [31:0] x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    // bitwise select: y where x is one, z where x is zero
    function automatic logic [31:0] f_choose(input logic [31:0] x, input logic [31:0] y,
                                             input logic [31:0] z);
        return z ^ (x & (y ^ z));
    endfunction

    // bitwise two-of-three vote
    function automatic logic [31:0] f_major(input logic [31:0] x, input logic [31:0] y,
                                            input logic [31:0] z);
        return (x & (y | z)) | (y & z);
    endfunction

endpackage

// File: rtl/sha_fold_round.sv
module sha_fold_round
    import sha_fold_pkg::*;
(
    input  sha_work_t   cur,
    input  logic [31:0] wk,
    output sha_work_t   nxt
);

    logic [31:0] pair_he;
    logic [31:0] pair_cw;
    logic [31:0] t1;
    logic [31:0] t2;

    // balanced tree: (h + S1) and (Ch + WK) evaluate side by side
    always_comb begin
        pair_he = cur.h + big_s1(cur.e);
        pair_cw = f_choose(cur.e, cur.f, cur.g) + wk;
        t1      = pair_he + pair_cw;
        t2      = big_s0(cur.a) + f_major(cur.a, cur.b, cur.c);
        nxt.a   = t1 + t2;
        nxt.b   = cur.a;
        nxt.c   = cur.b;
        nxt.d   = cur.c;
        nxt.e   = cur.d + t1;
        nxt.f   = cur.e;
        nxt.g   = cur.f;
        nxt.h   = cur.g;
    end

endmodule

// File: rtl/sha_fold_rounds.sv
module sha_fold_rounds
    import sha_fold_pkg::*;
#(
    parameter int RPC = 8
) (
    input  sha_work_t         st_in,
    input  logic [RPC*32-1:0] wk,
    output sha_work_t         st_out
);

    sha_work_t stage [RPC+1];

    assign stage[0] = st_in;

    generate
        for (genvar r = 0; r < RPC; r++) begin : g_round
            sha_fold_round u_round (
                .cur (stage[r]),
                .wk  (wk[r*32 +: 32]),
                .nxt (stage[r+1])
            );
        end
    endgenerate

    assign st_out = stage[RPC];

endmodule

// File: rtl/sha_fold_feedfwd.sv
module sha_fold_feedfwd
    import sha_fold_pkg::*;
(
    input  sha_work_t    work,
    input  sha_work_t    chain,
    output logic [255:0] sum
);

    localparam int WORDS = 8;

    logic [255:0] work_v;
    logic [255:0] chain_v;

    assign work_v  = work;
    assign chain_v = chain;

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign sum[w*32 +: 32] = work_v[w*32 +: 32] + chain_v[w*32 +: 32];
        end
    endgenerate

endmodule

// File: rtl/sha_fold_ctrl.sv
module sha_fold_ctrl
    import sha_fold_pkg::*;
#(
    parameter int STEPS = 8,
    parameter int GW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load_o,
    output logic          step_o,
    output logic          feed_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [GW-1:0] grp_o
);

    localparam logic [GW-1:0] LAST_GRP = GW'(STEPS - 1);

    fold_state_e   state_q;
    fold_state_e   state_d;
    logic [GW-1:0] grp_q;
    logic          last_grp;

    assign last_grp = (grp_q == LAST_GRP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // group counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else if (load_o) begin
            grp_q <= '0;
        end else if (step_o) begin
            grp_q <= last_grp ? '0 : grp_q + GW'(1);
        end
    end

    // transitions: launch, last group, commit, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)    state_d = ST_ROUNDS;
            ST_ROUNDS: if (last_grp) state_d = ST_FEED;
            ST_FEED:                 state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        feed_o = 1'b0;
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load_o = start;
            end
            ST_ROUNDS: step_o = 1'b1;
            ST_FEED:   feed_o = 1'b1;
            ST_DONE:   done_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    assign grp_o = grp_q;

endmodule

// File: rtl/sha_fold_core.sv
module sha_fold_core
    import sha_fold_pkg::*;
#(
    parameter  int RPC   = 8,
    localparam int STEPS = 64 / RPC,
    localparam int GW    = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [255:0]      init_state,
    input  logic [RPC*32-1:0] wk_in,
    output logic              busy,
    output logic              done,
    output logic [GW-1:0]     grp_idx,
    output logic [255:0]      digest
);

    sha_work_t    work_q;
    sha_work_t    chain_q;
    sha_work_t    work_nx;
    logic [255:0] digest_q;
    logic [255:0] ff_sum;
    logic         load;
    logic         step;
    logic         feed;

    sha_fold_ctrl #(
        .STEPS (STEPS),
        .GW    (GW)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load_o (load),
        .step_o (step),
        .feed_o (feed),
        .busy_o (busy),
        .done_o (done),
        .grp_o  (grp_idx)
    );

    sha_fold_rounds #(
        .RPC (RPC)
    ) u_rounds (
        .st_in  (work_q),
        .wk     (wk_in),
        .st_out (work_nx)
    );

    sha_fold_feedfwd u_ff (
        .work  (work_q),
        .chain (chain_q),
        .sum   (ff_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (load) begin
            work_q <= init_state;
        end else if (step) begin
            work_q <= work_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (load) begin
            chain_q <= init_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            digest_q <= '0;
        end else if (feed) begin
            digest_q <= ff_sum;
        end
    end

    assign digest = digest_q;

endmodule

// File: rtl/sha_fold_core_chk.sv
module sha_fold_core_chk #(
    parameter  int RPC   = 8,
    localparam int STEPS = 64 / RPC,
    localparam int GW    = $clog2(STEPS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [GW-1:0] grp_idx,
    input logic [255:0]  digest
);

    localparam int CW = 8;
    localparam logic [CW-1:0] CNT_MAX  = '1;
    localparam logic [CW-1:0] DONE_CNT = CW'(STEPS + 2);
    localparam logic [CW-1:0] RUN_END  = CW'(STEPS);

    logic [CW-1:0] run_cnt;

    // edges since the accepted start, counted independently of the controller
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!busy && start) begin
            run_cnt <= CW'(1);
        end else if (busy && run_cnt != CNT_MAX) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && grp_idx == '0));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3
    grp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt >= CW'(2) && run_cnt <= RUN_END) |-> (grp_idx == $past(grp_idx) + GW'(1)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == DONE_CNT && busy));

    // R7
    digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || done) |=> $stable(digest));

endmodule

bind sha_fold_core sha_fold_core_chk #(
    .RPC (RPC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .grp_idx (grp_idx),
    .digest  (digest)
);

// File: tb/sha_fold_core_test.sv
module sha_fold_core_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [255:0] IV_STD = {
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    localparam logic [255:0] ABC_KAT = {
        32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
        32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
    localparam logic [511:0] ABC_BLK = {32'h61626380, 448'h0, 32'h00000018};

    localparam logic [31:0] KT [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic         launch;
    logic [255:0] init_state;
    logic [31:0]  wk_arr [64];
    logic [255:0] dg [4];
    logic         dn [4];
    logic         bz [4];
    logic [2:0]   grp8;
    logic [255:0] wk8;
    logic [255:0] cur_exp;
    logic [255:0] prev_exp;
    logic [511:0] blk;
    int           since;
    int           n_run;
    int           n_fail;
    bit           mon_en;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- stimulus feeders and instances ----------------
    always_comb begin
        for (int j = 0; j < 8; j++) wk8[j*32 +: 32] = wk_arr[int'(grp8) * 8 + j];
    end

    sha_fold_core #(.RPC(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .init_state (init_state),
        .wk_in      (wk8),
        .busy       (bz[3]),
        .done       (dn[3]),
        .grp_idx    (grp8),
        .digest     (dg[3])
    );

    generate
        for (genvar g = 0; g < 3; g++) begin : fold_inst
            localparam int FR  = 1 << g;
            localparam int GWI = $clog2(64 / FR);
            logic [FR*32-1:0] wkb;
            logic [GWI-1:0]   gidx;
            always_comb begin
                for (int j = 0; j < FR; j++) wkb[j*32 +: 32] = wk_arr[int'(gidx) * FR + j];
            end
            sha_fold_core #(.RPC(FR)) dut (
                .clk        (clk),
                .rst_n      (rst_n),
                .start      (start),
                .init_state (init_state),
                .wk_in      (wkb),
                .busy       (bz[g]),
                .done       (dn[g]),
                .grp_idx    (gidx),
                .digest     (dg[g])
            );
        end
    endgenerate

    // ---------------- behavioural reference ----------------
    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        logic [63:0] d;
        d = {x, x} >> n;
        return d[31:0];
    endfunction

    task automatic build_wk(input logic [511:0] b);
        logic [31:0] w [64];
        for (int i = 0; i < 64; i++) begin
            if (i < 16) w[i] = b[511 - 32*i -: 32];
            else w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
                      + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
            wk_arr[i] = w[i] + KT[i];
        end
    endtask

    function automatic logic [255:0] sha_ref(input logic [255:0] st);
        logic [31:0] v [8];
        logic [31:0] t1;
        logic [31:0] t2;
        for (int i = 0; i < 8; i++) v[i] = st[255 - 32*i -: 32];
        for (int r = 0; r < 64; r++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) | (~v[4] & v[6])) + wk_arr[r];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            for (int i = 7; i > 0; i--) v[i] = v[i-1];
            v[4] = v[4] + t1;
            v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) v[i] = v[i] + st[255 - 32*i -: 32];
        return {v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // ---------------- cycle model: edges since accepted launch ----------------
    always @(posedge clk) begin
        if (!rst_n) since <= 0;
        else if (launch) since <= 1;
        else if (since > 0 && since < 200) since <= since + 1;
    end

    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            for (int g = 0; g < 4; g++) begin
                int s;
                bit eb;
                bit ed;
                logic [255:0] edg;
                s   = 64 >> g;
                eb  = (since >= 1 && since <= s + 2);
                ed  = (since == s + 2);
                edg = (since >= s + 2) ? cur_exp : prev_exp;
                check(bz[g] == eb, "R6", $sformatf("busy rpc=%0d", 1 << g), 256'(bz[g]), 256'(eb));
                check(dn[g] == ed, "R6", $sformatf("done rpc=%0d", 1 << g), 256'(dn[g]), 256'(ed));
                check(dg[g] == edg, "R7", $sformatf("digest rpc=%0d", 1 << g), dg[g], edg);
            end
            if (since >= 1 && since <= 8)
                check(grp8 == 3'(since - 1), "R3", "group index", 256'(grp8), 256'(since - 1));
        end
    end

    // ---------------- sequences ----------------
    task automatic launch_msg(input logic [255:0] st, input logic [511:0] b);
        @(negedge clk);
        #1;
        build_wk(b);
        prev_exp   = cur_exp;
        cur_exp    = sha_ref(st);
        init_state = st;
        start      = 1'b1;
        launch     = 1'b1;
        @(negedge clk);
        #1;
        start  = 1'b0;
        launch = 1'b0;
    endtask

    task automatic final_check(input string req);
        for (int g = 0; g < 4; g++)
            check(dg[g] == cur_exp, req, $sformatf("final digest rpc=%0d", 1 << g), dg[g], cur_exp);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; launch = 1'b0; init_state = '0;
        mon_en = 1'b0; cur_exp = '0; prev_exp = '0; n_run = 0; n_fail = 0;
        for (int i = 0; i < 64; i++) wk_arr[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int g = 0; g < 4; g++) begin
            check(!bz[g] && !dn[g], "R1", "reset flags", 256'({bz[g], dn[g]}), 256'(0));
            check(dg[g] == '0, "R1", "reset digest", dg[g], '0);
        end
        check(grp8 == '0, "R1", "reset group", 256'(grp8), 256'(0));
        #1;
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // R8 R4 R5: known answer at every folding factor
        launch_msg(IV_STD, ABC_BLK);
        check(cur_exp == ABC_KAT, "R4", "reference known answer", cur_exp, ABC_KAT);
        repeat (70) @(negedge clk);
        final_check("R8");

        // R2 R9: stray start and changed init during a run
        for (int i = 0; i < 16; i++) blk[511 - 32*i -: 32] = 32'h01020304 * (i + 1);
        launch_msg(ABC_KAT, blk);
        @(negedge clk);
        #1;
        start      = 1'b1;
        init_state = ~init_state;
        @(negedge clk);
        #1;
        start = 1'b0;
        repeat (70) @(negedge clk);
        final_check("R9");
        final_check("R2");

        // R5: carry-heavy operands
        launch_msg('1, '1);
        repeat (70) @(negedge clk);
        final_check("R5");

        // R1: reset in mid-run
        launch_msg(IV_STD, blk);
        repeat (3) @(negedge clk);
        #1;
        rst_n    = 1'b0;
        cur_exp  = '0;
        prev_exp = '0;
        @(negedge clk);
        for (int g = 0; g < 4; g++) begin
            check(!bz[g] && !dn[g], "R1", "mid-run reset flags", 256'({bz[g], dn[g]}), 256'(0));
            check(dg[g] == '0, "R1", "mid-run reset digest", dg[g], '0);
        end
        #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        launch_msg(IV_STD, ABC_BLK);
        repeat (70) @(negedge clk);
        final_check("R8");
        for (int g = 0; g < 4; g++)
            check(dg[g] == ABC_KAT, "R8", "known answer after reset", dg[g], ABC_KAT);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

endmodule